// File: doc/BRIEF.md
# Two-Way Interleaved Slow-Function Wrapper

This block lets a system present a new data word on every clock even though the arithmetic function applied to each word needs two clock periods to settle. It keeps two identical copies of the function, each fed by its own operand register. A one-bit turn machine hands successive clock slots to the copies in strict alternation. A copy's operand register loads only on its own turn, so its operand stays stable for two full cycles. A single output register takes each copy's result at the same edge at which that copy takes its next operand.

The function splits the input word into an upper half and a lower half. It multiplies the two halves and adds the lower half to the product. The result is as wide as the input word. Valid travels beside the data. A slot with valid low is a bubble: it takes its turn like any other slot but produces no result. The wrapper is used wherever a multicycle combinational unit has to keep up with a full-rate stream, and it adds a fixed latency.

The turn machine has two states. TURN_A steers the current slot to copy A, and TURN_B steers it to copy B. The transition A_TO_B fires on every active edge taken in TURN_A, and B_TO_A fires on every active edge taken in TURN_B, whatever the valid input is. Reset forces TURN_A, so the first slot after reset always goes to copy A.

Top module: `ilv_slow_wrap`

## Requirements
- R1: While rst_n is low at a rising edge, out_valid and out_data are 0 right after that edge.
- R2: For a valid input word x of DATA_W bits (default 16), define hi = x[DATA_W-1:DATA_W/2] and lo = x[DATA_W/2-1:0]. The reported result is (hi*lo + lo), taken modulo 2^DATA_W.
- R3: An input sampled with in_valid high at rising edge n is shown on out_valid and out_data right after rising edge n+2.
- R4: A valid word is accepted at every rising edge. Back-to-back words come out on consecutive cycles, in the order they went in, and each is paired with its own result.
- R5: A slot sampled with in_valid low gives out_valid low exactly two edges later. The results of the valid words on either side are unaffected.
- R6: While out_valid is low, out_data keeps the last result it showed (or 0 if none has been shown since reset).
- R7: Each copy's operand changes only at an edge where that copy has its turn and in_valid is high, so every result is computed from the operand its own slot delivered.
- R8: Reset in the middle of a stream discards every word in flight. The first word after reset is still reported correctly, with the latency of R3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Input word is valid in this slot |
| in_data | input | DATA_W | Input word (upper and lower halves are the operands) |
| out_valid | output | 1 | out_data carries a new result |
| out_data | output | DATA_W | Registered function result |

## Verification
Suppose the turn state fell out of step with the output multiplexer, or an operand register loaded outside its turn. The next valid word would then come out carrying the result of its neighbour, or of a word from two slots earlier, two edges after it was sampled. Alternating and repeated data patterns, with bubbles placed on both even and odd slots, make such a swap visible on the first affected word. A flaw in the valid pipeline would show up at once as out_valid being out of step with the input pattern. It would also break the rule that out_data holds its value through bubbles.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    // Which copy owns the current clock slot.
    typedef enum logic {
        TURN_A = 1'b0,
        TURN_B = 1'b1
    } turn_e;

    localparam int unsigned NUM_COPIES = 2;

endpackage : ilv_pkg

// File: rtl/ilv_turn_fsm.sv
module ilv_turn_fsm
    import ilv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    output turn_e                 turn,
    output logic [NUM_COPIES-1:0] load_en
);

    turn_e turn_q;
    turn_e turn_d;

    // Next-state logic: flip on every edge, whatever the valid input is.
    always_comb begin
        unique case (turn_q)
            TURN_A:  turn_d = TURN_B;   // A_TO_B
            TURN_B:  turn_d = TURN_A;   // B_TO_A
            default: turn_d = TURN_A;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) turn_q <= TURN_A;
        else        turn_q <= turn_d;
    end

    // Output decode: only the owning copy may load, and only for a valid slot.
    always_comb begin
        load_en = '0;
        unique case (turn_q)
            TURN_A:  load_en[0] = in_valid;
            TURN_B:  load_en[1] = in_valid;
            default: load_en    = '0;
        endcase
    end

    assign turn = turn_q;

    AST_TOGGLE_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (turn_q != $past(turn_q)));  // R4

endmodule : ilv_turn_fsm

// File: rtl/ilv_hold_reg.sv
module ilv_hold_reg #(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] d,
    output logic [DATA_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (load_en) q <= d;
    end

    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(load_en)) |-> $stable(q));  // R7

endmodule : ilv_hold_reg

// File: rtl/ilv_slow_fn.sv
module ilv_slow_fn #(
    parameter int unsigned DATA_W = 16
) (
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);

    localparam int unsigned HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] hi_ext;
    logic [DATA_W-1:0] lo_ext;

    // Two-cycle path: the operand is held stable for two periods by its register.
    always_comb begin
        hi_ext = {{(DATA_W-HALF_W){1'b0}}, operand[DATA_W-1:HALF_W]};
        lo_ext = {{(DATA_W-HALF_W){1'b0}}, operand[HALF_W-1:0]};
        result = (hi_ext * lo_ext) + lo_ext;
    end

endmodule : ilv_slow_fn

// File: rtl/ilv_out_stage.sv
module ilv_out_stage
    import ilv_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               in_valid,
    input  turn_e                              turn,
    input  logic [NUM_COPIES-1:0][DATA_W-1:0]  res_bus,
    output logic                               out_valid,
    output logic [DATA_W-1:0]                  out_data
);

    logic              v1_q;
    logic              v2_q;
    logic [DATA_W-1:0] res_sel;

    // The copy whose turn it is again has held its operand for two cycles.
    always_comb begin
        unique case (turn)
            TURN_A:  res_sel = res_bus[0];
            TURN_B:  res_sel = res_bus[1];
            default: res_sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1_q      <= 1'b0;
            v2_q      <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            v1_q      <= in_valid;
            v2_q      <= v1_q;
            out_valid <= v2_q;
            if (v2_q) out_data <= res_sel;
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_valid) |-> $stable(out_data));  // R6

endmodule : ilv_out_stage

// File: rtl/ilv_slow_wrap.sv
module ilv_slow_wrap
    import ilv_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    turn_e                              turn;
    logic [NUM_COPIES-1:0]              load_en;
    logic [NUM_COPIES-1:0][DATA_W-1:0]  held;
    logic [NUM_COPIES-1:0][DATA_W-1:0]  res_bus;

    ilv_turn_fsm u_turn (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .turn     (turn),
        .load_en  (load_en)
    );

    for (genvar c = 0; c < NUM_COPIES; c++) begin : g_copy
        ilv_hold_reg #(.DATA_W(DATA_W)) u_hold (
            .clk     (clk),
            .rst_n   (rst_n),
            .load_en (load_en[c]),
            .d       (in_data),
            .q       (held[c])
        );

        ilv_slow_fn #(.DATA_W(DATA_W)) u_fn (
            .operand (held[c]),
            .result  (res_bus[c])
        );
    end

    ilv_out_stage #(.DATA_W(DATA_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .turn      (turn),
        .res_bus   (res_bus),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
            |-> (out_valid == $past(in_valid, 3)));  // R3

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && (out_data == '0)));  // R1

endmodule : ilv_slow_wrap

// File: tb/ilv_slow_wrap_tb.sv
module ilv_slow_wrap_tb_top;

    localparam int unsigned DW    = 16;
    localparam int unsigned NVEC  = 20;
    localparam int unsigned NRAND = 160;

    // {valid, data}
    localparam logic [DW:0] VEC [NVEC] = '{
        17'h1_0000, 17'h1_FFFF, 17'h1_0100, 17'h1_00FF, 17'h1_1234,
        17'h1_1234, 17'h0_ABCD, 17'h1_0203, 17'h1_FF01, 17'h0_0000,
        17'h0_5555, 17'h1_8080, 17'h1_0001, 17'h0_FFFF, 17'h1_7F7F,
        17'h1_00FF, 17'h1_FF00, 17'h0_1111, 17'h1_0A0B, 17'h1_C3A5
    };

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic [DW-1:0] in_data;
    logic          out_valid;
    logic [DW-1:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [DW:0]   sh1, sh2, sh3;
    logic [DW-1:0] last_res;

    always #4 clk = ~clk;

    ilv_slow_wrap #(.DATA_W(DW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    function automatic logic [DW-1:0] ref_fn(input logic [DW-1:0] x);
        int unsigned a;
        int unsigned b;
        a = int'(x[15:8]);
        b = int'(x[7:0]);
        return DW'((a * b + b) % 65536);
    endfunction

    task automatic check_out(input logic ev, input logic [DW-1:0] ed, input string req);
        checks++;
        if (out_valid !== ev || out_data !== ed) begin
            errors++;
            $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                     req, out_valid, out_data, ev, ed);
        end
    endtask

    // One slot: check the word driven three slots ago, then drive a new one.
    task automatic slot(input logic [DW:0] vec, input string req);
        @(negedge clk);
        if (sh3[DW]) last_res = ref_fn(sh3[DW-1:0]);
        check_out(sh3[DW], last_res, req);
        sh3 = sh2;
        sh2 = sh1;
        sh1 = vec;
        in_valid = vec[DW];
        in_data  = vec[DW-1:0];
    endtask

    task automatic do_reset(input string req);
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        in_data  = '0;
        @(negedge clk);
        check_out(1'b0, '0, req);
        sh1 = '0; sh2 = '0; sh3 = '0;
        last_res = '0;
        rst_n = 1'b1;
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
        sh1 = '0; sh2 = '0; sh3 = '0; last_res = '0;

        // R1: reset state
        do_reset("R1 reset state");

        // Vector table: function values (R2), latency (R3), back-to-back (R4),
        // bubbles on even and odd slots (R5) and holding during bubbles (R6).
        for (int k = 0; k < NVEC; k++) slot(VEC[k], "R2/R3 table R4 R5 R6");
        for (int k = 0; k < 3; k++) slot('0, "R5 R6 flush");

        // Directed: a single word after idle, latency exactly two edges past sampling (R3).
        slot({1'b1, 16'h0F0F}, "R3");
        slot('0, "R3 idle");
        slot('0, "R3 idle");
        slot('0, "R3 result slot");
        slot('0, "R6 hold after result");

        // R8: reset with words in flight; nothing from before the reset may appear.
        slot({1'b1, 16'h2222}, "R8 preload");
        slot({1'b1, 16'h3333}, "R8 preload");
        do_reset("R8 reset mid-stream");
        slot({1'b1, 16'h0910}, "R8 first after reset");
        slot('0, "R8 no stale output");
        slot('0, "R8 no stale output");
        slot('0, "R8 first result");
        slot('0, "R8 hold");

        // Random back-to-back stream with about one bubble in five: alternation and
        // operand holding (R7), order (R4).
        for (int k = 0; k < NRAND; k++) begin
            logic [DW:0] v;
            v[DW-1:0] = DW'($urandom);
            v[DW]     = ($urandom % 5) != 0;
            slot(v, "R7 R4 random");
        end
        for (int k = 0; k < 4; k++) slot('0, "R7 drain");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule : ilv_slow_wrap_tb_top